// File: doc/BRIEF.md
# Chroma Quadrature Demodulator

This block turns a stream of signed 8-bit modulated chroma samples into two baseband colour-difference streams, U and V. An internal numerically controlled oscillator holds a 24-bit phase and produces two carriers 90 degrees apart from a single quarter-wave sine table. Each accepted sample is multiplied by both carriers. Each product then passes through a boxcar low-pass filter, and the filter length is picked per sample by a 2-bit code.

The carrier frequency comes from a 24-bit increment word. The word is chosen by the surrounding logic to suit the active colour standard. The phase moves forward only when a sample is accepted, so the oscillator stays locked to the sample stream. Both outputs have the same fixed pipeline latency and share one valid strobe. Between valid outputs the output values hold.

Top module: `chroma_quad_demod`

## Requirements
- R1: While reset is asserted and after it, until the first output: `out_valid` is 0, `u_out` and `v_out` are 0, the oscillator phase is 0 and both filter histories hold zeros. An assertion of reset in the middle of a run restores this state.
- R2: The carrier index is the top 8 bits of the 24-bit phase. The sine carrier for index i is round(127 * sin(2*pi*(i+0.5)/256)). The cosine carrier uses index (i+64) mod 256. The values come from one 64-entry quarter-wave table folded by quadrant.
- R3: A sample accepted with `in_valid` = 1 is mixed at the current phase. The phase then advances by the `freq_word` presented with that sample, modulo 2^24. When `in_valid` is 0 the phase holds.
- R4: The U product is sample * cosine carrier and the V product is sample * sine carrier, both as signed integers.
- R5: Code k on `filt_sel`, presented with a sample, makes that sample's outputs the sum of the latest 2^k products of each channel, the current one included. Codes 0, 1, 2 and 3 give 1, 2, 4 and 8 taps.
- R6: Each output is floor((sum + 2^(6+k)) / 2^(7+k)) for code k, saturated to the range -128..127.
- R7: `out_valid` rises exactly 3 clock cycles after the cycle in which `in_valid` is 1, and is 0 three cycles after a cycle with `in_valid` = 0. U and V belong to the same sample.
- R8: `u_out` and `v_out` hold their values in every cycle in which `out_valid` is 0.
- R9: The filter histories shift only on accepted samples. Idle cycles between samples have no effect on later outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample strobe |
| in_chroma | input | 8 | Signed modulated chroma sample |
| freq_word | input | 24 | Phase increment applied after the accepted sample |
| filt_sel | input | 2 | Filter length code travelling with the sample |
| out_valid | output | 1 | Output strobe |
| u_out | output | 8 | Signed U output |
| v_out | output | 8 | Signed V output |

## Verification
A wrong phase shows at the ports on the first valid output of the sample that used it, three cycles later. It then stays visible on every later output, because the accumulator never recovers by itself. A corrupted filter history entry shows up to eight accepted samples later, depending on the tap code. A slip in the valid pipeline breaks the output strobe alignment at once. The reference model therefore predicts the outputs every cycle, across idle gaps, tap-code changes and a reset in the middle of a run.

// File: rtl/cqd_pkg.sv
package cqd_pkg;

  localparam int PHASE_W  = 24;
  localparam int SMP_W    = 8;
  localparam int CAR_W    = 8;
  localparam int LUT_AW   = 6;
  localparam int LOG_TAPS = 3;
  localparam int SEL_W    = 2;

  // sine by series expansion, accurate far below one LSB on [0, pi/2]
  function automatic real series_sin(input real x);
    real term;
    real acc;
    term = x;
    acc  = x;
    for (int n = 1; n < 9; n++) begin
      term = -term * x * x / real'((2 * n) * (2 * n + 1));
      acc  = acc + term;
    end
    return acc;
  endfunction

  // entry k of the quarter table, sampled at the bin centre
  function automatic int quarter_entry(input int k, input int aw, input int amp);
    real ang;
    ang = 3.14159265358979 * real'(2 * k + 1) / real'(4 << aw);
    return int'(real'(amp) * series_sin(ang));
  endfunction

endpackage

// File: rtl/cqd_nco.sv
module cqd_nco #(
  parameter int PHASE_W = cqd_pkg::PHASE_W,
  parameter int LUT_AW  = cqd_pkg::LUT_AW,
  parameter int CAR_W   = cqd_pkg::CAR_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      adv,
  input  logic [PHASE_W-1:0]        step,
  output logic signed [CAR_W-1:0]   sin_o,
  output logic signed [CAR_W-1:0]   cos_o
);

  localparam int IDX_W   = LUT_AW + 2;
  localparam int ENTRIES = 1 << LUT_AW;
  localparam int AMP     = (1 << (CAR_W - 1)) - 1;

  logic [PHASE_W-1:0] phase_q, phase_d;
  logic [IDX_W-1:0]   idx_sin, idx_cos;
  logic signed [CAR_W-1:0] qlut [ENTRIES];

  for (genvar k = 0; k < ENTRIES; k++) begin : g_lut
    localparam int EV = cqd_pkg::quarter_entry(k, LUT_AW, AMP);
    assign qlut[k] = CAR_W'(EV);
  end

  always_comb phase_d = phase_q + step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   phase_q <= '0;
    else if (adv) phase_q <= phase_d;
  end

  assign idx_sin = phase_q[PHASE_W-1 -: IDX_W];
  assign idx_cos = idx_sin + IDX_W'(ENTRIES);

  for (genvar t = 0; t < 2; t++) begin : g_tap
    logic [IDX_W-1:0]        ix;
    logic [LUT_AW-1:0]       addr;
    logic signed [CAR_W-1:0] mag;
    logic signed [CAR_W-1:0] val;
    assign ix = (t == 0) ? idx_sin : idx_cos;
    always_comb begin
      addr = ix[LUT_AW] ? ~ix[LUT_AW-1:0] : ix[LUT_AW-1:0];
      mag  = qlut[addr];
      val  = ix[LUT_AW+1] ? -mag : mag;
    end
  end

  assign sin_o = g_tap[0].val;
  assign cos_o = g_tap[1].val;

  a_r3_phase_holds_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(phase_q));

  a_r2_first_quadrant_positive: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_sin[IDX_W-1 -: 2] == 2'b00) |-> (sin_o > 0 && cos_o > 0));

  a_r2_third_quadrant_negative: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_sin[IDX_W-1 -: 2] == 2'b10) |-> (sin_o < 0 && cos_o < 0));

endmodule

// File: rtl/cqd_boxcar.sv
module cqd_boxcar #(
  parameter int PROD_W   = 2 * cqd_pkg::SMP_W,
  parameter int OUT_W    = cqd_pkg::SMP_W,
  parameter int LOG_TAPS = cqd_pkg::LOG_TAPS,
  parameter int SEL_W    = cqd_pkg::SEL_W,
  parameter int SCALE_SH = cqd_pkg::CAR_W - 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_en,
  input  logic signed [PROD_W-1:0] prod_i,
  input  logic                     load_en,
  input  logic [SEL_W-1:0]         sel_i,
  output logic signed [OUT_W-1:0]  y_o
);

  localparam int TAPS  = 1 << LOG_TAPS;
  localparam int SUM_W = PROD_W + LOG_TAPS;
  localparam int ACC_W = SUM_W + 1;
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MINV = -ACC_W'(1 << (OUT_W - 1));

  logic signed [PROD_W-1:0] hist_q [TAPS];
  logic signed [SUM_W-1:0]  sum_sel;
  logic signed [ACC_W-1:0]  bias, acc, q;
  logic signed [OUT_W-1:0]  y_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) hist_q[i] <= '0;
    end else if (shift_en) begin
      hist_q[0] <= prod_i;
      for (int i = 1; i < TAPS; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  always_comb begin
    sum_sel = '0;
    for (int i = 0; i < TAPS; i++)
      if (i < (1 << sel_i)) sum_sel = sum_sel + SUM_W'(hist_q[i]);
    bias = ACC_W'(1) << (SCALE_SH - 1 + int'(sel_i));
    acc  = ACC_W'(sum_sel) + bias;
    q    = acc >>> (SCALE_SH + int'(sel_i));
    if (q > MAXV)      y_d = MAXV[OUT_W-1:0];
    else if (q < MINV) y_d = MINV[OUT_W-1:0];
    else               y_d = q[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       y_o <= '0;
    else if (load_en) y_o <= y_d;
  end

  a_r6_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !sum_sel[SUM_W-1]) |=> !y_o[OUT_W-1]);

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(y_o));

endmodule

// File: rtl/chroma_quad_demod.sv
module chroma_quad_demod #(
  parameter int PHASE_W  = cqd_pkg::PHASE_W,
  parameter int SMP_W    = cqd_pkg::SMP_W,
  parameter int CAR_W    = cqd_pkg::CAR_W,
  parameter int LUT_AW   = cqd_pkg::LUT_AW,
  parameter int LOG_TAPS = cqd_pkg::LOG_TAPS,
  parameter int SEL_W    = cqd_pkg::SEL_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [SMP_W-1:0]  in_chroma,
  input  logic [PHASE_W-1:0]       freq_word,
  input  logic [SEL_W-1:0]         filt_sel,
  output logic                     out_valid,
  output logic signed [SMP_W-1:0]  u_out,
  output logic signed [SMP_W-1:0]  v_out
);

  localparam int PROD_W = SMP_W + CAR_W;

  logic [1:0] rst_sync;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  logic signed [CAR_W-1:0] car_sin, car_cos;

  cqd_nco #(.PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .CAR_W(CAR_W)) nco_i (
    .clk   (clk),
    .rst_n (rst_i),
    .adv   (in_valid),
    .step  (freq_word),
    .sin_o (car_sin),
    .cos_o (car_cos)
  );

  // stage 1: mixers
  logic signed [PROD_W-1:0] prod_d [2];
  logic signed [PROD_W-1:0] prod_q [2];
  logic                     v1_q, v2_q, v3_q;
  logic [SEL_W-1:0]         sel1_q, sel2_q;

  always_comb begin
    prod_d[0] = PROD_W'(in_chroma) * PROD_W'(car_cos);
    prod_d[1] = PROD_W'(in_chroma) * PROD_W'(car_sin);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      prod_q[0] <= '0;
      prod_q[1] <= '0;
      sel1_q    <= '0;
    end else if (in_valid) begin
      prod_q[0] <= prod_d[0];
      prod_q[1] <= prod_d[1];
      sel1_q    <= filt_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)    sel2_q <= '0;
    else if (v1_q) sel2_q <= sel1_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else begin
      v1_q <= in_valid;
      v2_q <= v1_q;
      v3_q <= v2_q;
    end
  end

  // stages 2 and 3: one filter per channel
  logic signed [SMP_W-1:0] y_ch [2];

  for (genvar c = 0; c < 2; c++) begin : g_ch
    cqd_boxcar #(
      .PROD_W(PROD_W), .OUT_W(SMP_W), .LOG_TAPS(LOG_TAPS),
      .SEL_W(SEL_W), .SCALE_SH(CAR_W - 1)
    ) filt_i (
      .clk      (clk),
      .rst_n    (rst_i),
      .shift_en (v1_q),
      .prod_i   (prod_q[c]),
      .load_en  (v2_q),
      .sel_i    (sel2_q),
      .y_o      (y_ch[c])
    );
  end

  assign out_valid = v3_q;
  assign u_out     = y_ch[0];
  assign v_out     = y_ch[1];

  a_r7_latency_valid: assert property (@(posedge clk) disable iff (!rst_i)
    in_valid |-> ##3 out_valid);

  a_r7_latency_idle: assert property (@(posedge clk) disable iff (!rst_i)
    !in_valid |-> ##3 !out_valid);

  a_r8_outputs_hold: assert property (@(posedge clk) disable iff (!rst_i)
    !out_valid |-> ($stable(u_out) && $stable(v_out)));

endmodule

// File: tb/chroma_quad_demod_tb_top.sv
module chroma_quad_demod_tb_top;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic signed [7:0] in_chroma;
  logic [23:0]       freq_word;
  logic [1:0]        filt_sel;
  logic              out_valid;
  logic signed [7:0] u_out, v_out;

  always #2 clk = ~clk;

  chroma_quad_demod dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chroma(in_chroma),
    .freq_word(freq_word), .filt_sel(filt_sel), .out_valid(out_valid),
    .u_out(u_out), .v_out(v_out)
  );

  int checks = 0;
  int failures = 0;

  typedef struct { bit v; int u; int w; } exp_t;
  exp_t        pipe[$];
  int          hu[$];
  int          hv[$];
  logic [23:0] m_phase;
  int          last_u, last_v;
  string       tag;

  function automatic int carrier(input int idx);
    real th;
    th = 2.0 * 3.14159265358979 * (real'(idx % 256) + 0.5) / 256.0;
    return int'(127.0 * $sin(th));
  endfunction

  function automatic int filt(ref int h[$], input int sel);
    int sum, sh, y;
    sum = 0;
    for (int i = 0; i < (1 << sel); i++) sum += h[i];
    sh = 7 + sel;
    y = (sum + (1 << (sh - 1))) >>> sh;
    if (y > 127) y = 127;
    if (y < -128) y = -128;
    return y;
  endfunction

  task automatic model_clear();
    hu.delete(); hv.delete(); pipe.delete();
    for (int i = 0; i < 8; i++) begin hu.push_back(0); hv.push_back(0); end
    for (int i = 0; i < 3; i++) pipe.push_back('{0, 0, 0});
    m_phase = '0; last_u = 0; last_v = 0;
  endtask

  task automatic check_out(input exp_t o);
    if (o.v) begin last_u = o.u; last_v = o.w; end
    checks++;
    if (out_valid !== o.v) begin
      failures++;
      $display("FAIL R7 out_valid actual=%0b expected=%0b", out_valid, o.v);
    end
    checks++;
    if (int'(u_out) != last_u || int'(v_out) != last_v) begin
      failures++;
      if (o.v)
        $display("FAIL %s R4 R6 u/v actual=%0d/%0d expected=%0d/%0d",
                 tag, u_out, v_out, last_u, last_v);
      else
        $display("FAIL R8 hold u/v actual=%0d/%0d expected=%0d/%0d",
                 u_out, v_out, last_u, last_v);
    end
  endtask

  task automatic tick(input bit v, input int x, input int f, input int sel);
    exp_t o, e;
    int   idx;
    @(negedge clk);
    o = pipe.pop_front();
    check_out(o);
    in_valid  = v;
    in_chroma = x[7:0];
    freq_word = f[23:0];
    filt_sel  = sel[1:0];
    e = '{v, 0, 0};
    if (v) begin
      idx = int'(m_phase[23:16]);
      hu.push_front(x * carrier(idx + 64)); void'(hu.pop_back());
      hv.push_front(x * carrier(idx));      void'(hv.pop_back());
      e.u = filt(hu, sel);
      e.w = filt(hv, sel);
      m_phase = m_phase + f[23:0];
    end
    pipe.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || u_out !== 8'sd0 || v_out !== 8'sd0) begin
      failures++;
      $display("FAIL R1 reset outputs actual=%0b/%0d/%0d expected=0/0/0",
               out_valid, u_out, v_out);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || u_out !== 8'sd0 || v_out !== 8'sd0) begin
      failures++;
      $display("FAIL R1 after release actual=%0b/%0d/%0d expected=0/0/0",
               out_valid, u_out, v_out);
    end
    model_clear();
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_chroma = '0; freq_word = '0; filt_sel = '0;
    model_clear();
    do_reset();

    // R2 R3: zero increment keeps phase at 0
    tag = "R3";
    for (int i = 0; i < 10; i++) tick(1, 100, 0, 0);
    idle(4);

    // R2 R4: quarter-cycle steps walk all quadrants
    tag = "R2";
    for (int i = 0; i < 20; i++) tick(1, 127, 24'h400000, 0);
    idle(4);

    // R5 R6: every tap code with a varied input
    tag = "R5";
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 24; i++) tick(1, ((i * 37 + s * 11) % 256) - 128, 24'h0A3D71, s);
      idle(4);
    end

    // R9 R3 R8: gaps between samples
    tag = "R9";
    for (int i = 0; i < 30; i++) begin
      tick(1, (i * 53) % 200 - 100, 24'h123456, 3);
      if (i % 3 == 0) idle(2);
    end
    idle(4);

    // R6: extreme inputs, half-cycle steps
    tag = "R6";
    for (int i = 0; i < 16; i++) tick(1, -128, 24'h800000, 3);
    for (int i = 0; i < 16; i++) tick(1, 127, 24'h7FFFFF, i % 4);
    idle(4);

    // R5: tap code changes with every sample
    tag = "R5";
    for (int i = 0; i < 40; i++) tick(1, (i * 91) % 256 - 128, 24'h2D82D8, (i * 3) % 4);
    idle(4);

    // R1: reset mid-run, then resume from zero phase
    tag = "R1";
    for (int i = 0; i < 6; i++) tick(1, 90, 24'h1F0000, 2);
    do_reset();
    for (int i = 0; i < 12; i++) tick(1, 60 - i * 10, 24'h051EB8, 1);
    idle(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule